// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block collects DMA transfer requests from two channels and decides, one transfer at a time, whether a DMA channel or the CPU holds the bus. Each channel keeps a single pending flag. Requests seen during a sampling window are folded into that flag when the window closes. A pulse on the window strobe marks the close of each window.

Channel 0 is always preferred over channel 1. A channel's pending flag drops on the cycle its grant is issued. Each grant lasts for exactly one transfer, which ends with a transfer-complete pulse. After every DMA transfer the CPU must finish one bus access, marked by a CPU-complete pulse, before any channel is granted again. This rule also applies to a lower-priority channel that has been waiting.

Top module: `dma_req_arb`

## Requirements
- R1: After synchronous active-high reset, both pending flags are 0, no grant is asserted and `cpu_own_o` is 1.
- R2: A channel whose enable is 1 and whose request line was high on any cycle of the current window, including the strobe cycle, shows its pending flag set on the cycle after the strobe. When both channels are requested in one window, both flags rise on the same cycle.
- R3: A request on a channel whose enable is 0 leaves its pending flag at 0 and produces no grant.
- R4: Several requests on one channel before it is served merge into one pending flag and produce exactly one transfer.
- R5: When both channels are pending and the bus is free for DMA, `grant_o` becomes 2'b01 (bit 0 = channel 0), not 2'b10.
- R6: A channel's pending flag clears on the same cycle its grant bit rises, unless a window closes on that edge with a new request for that channel.
- R7: A grant stays asserted until a `xfer_done_i` pulse. On the next cycle the grant is 0 and `cpu_own_o` is 1.
- R8: After a transfer ends, no grant is issued until `cpu_done_i` has pulsed. The next grant rises one cycle after that pulse. Before the first transfer after reset, no CPU access is needed.
- R9: A request on a channel arriving during its own transfer sets its pending flag again. That channel is served once the CPU access following the transfer has completed.
- R10: Clearing a channel's enable clears its pending flag on the next cycle. A grant already held by that channel stays until `xfer_done_i`.
- R11: At most one grant bit is 1 at a time, and `cpu_own_o` is 1 exactly when no grant bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Per-channel transfer request lines |
| en_i | input | 2 | Per-channel enable bits |
| win_i | input | 1 | Single-cycle strobe closing a sampling window |
| cpu_done_i | input | 1 | Pulse: CPU finished one bus access |
| xfer_done_i | input | 1 | Pulse: current DMA transfer finished |
| pend_o | output | 2 | Per-channel pending flags |
| grant_o | output | 2 | One-hot channel grant |
| cpu_own_o | output | 1 | CPU holds the bus |

## Verification
Two functions can fall on the same edge. In one case, a window closes with a fresh request on the channel currently holding the bus, so setting the pending flag meets an active grant. In the other, both channels latch in one window, so simultaneous setting meets priority selection. Directed sequences provoke each case: one raises a request during a channel's own transfer, and the other raises both requests inside one window. The bench then judges the flags, grant and CPU ownership cycle by cycle against values derived from the requirements, including the mandatory CPU access that separates the two grants.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        BUS_FREE = 2'd0,   // CPU owns bus, DMA may take it
        BUS_DMA  = 2'd1,   // one DMA transfer in flight
        BUS_CPU  = 2'd2    // CPU owns bus, must finish one access
    } bus_st_e;

endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic en_i,
    input  logic win_i,
    input  logic clr_i,
    output logic pend_o
);

    typedef struct packed {
        logic seen;
        logic pend;
    } lat_t;

    lat_t r_q, r_d;

    always_comb begin
        logic hit;
        r_d = r_q;
        hit = req_i & en_i;
        if (win_i) begin
            r_d.seen = 1'b0;
            r_d.pend = (r_q.pend & ~clr_i) | r_q.seen | hit;
        end else begin
            r_d.seen = r_q.seen | hit;
            r_d.pend = r_q.pend & ~clr_i;
        end
        if (!en_i) begin
            r_d.seen = 1'b0;
            r_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign pend_o = r_q.pend;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] pick_o,
    output logic         any_o
);

    always_comb begin
        logic found;
        pick_o = '0;
        found  = 1'b0;
        for (int c = 0; c < N; c++) begin
            if (cand_i[c] && !found) begin
                pick_o[c] = 1'b1;
                found     = 1'b1;
            end
        end
        any_o = found;
    end

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
    import dma_arb_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pick_i,
    input  logic         any_i,
    input  logic         cpu_done_i,
    input  logic         xfer_done_i,
    output logic [N-1:0] clr_o,
    output logic [N-1:0] grant_o,
    output logic         cpu_own_o
);

    typedef struct packed {
        bus_st_e      st;
        logic [N-1:0] grant;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d   = s_q;
        clr_o = '0;
        unique case (s_q.st)
            BUS_FREE: begin
                if (any_i) begin
                    s_d.st    = BUS_DMA;
                    s_d.grant = pick_i;
                    clr_o     = pick_i;
                end
            end
            BUS_DMA: begin
                if (xfer_done_i) begin
                    s_d.st    = BUS_CPU;
                    s_d.grant = '0;
                end
            end
            BUS_CPU: begin
                if (cpu_done_i) s_d.st = BUS_FREE;
            end
            default: begin
                s_d.st    = BUS_FREE;
                s_d.grant = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st    <= BUS_FREE;
            s_q.grant <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_o   = s_q.grant;
    assign cpu_own_o = (s_q.st != BUS_DMA);

endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] en_i,
    input  logic         win_i,
    input  logic         cpu_done_i,
    input  logic         xfer_done_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] grant_o,
    output logic         cpu_own_o
);

    logic [N-1:0] clr_w;
    logic [N-1:0] pick_w;
    logic         any_w;

    for (genvar c = 0; c < N; c++) begin : g_ch
        dma_req_latch lat_i (
            .clk    (clk),
            .rst    (rst),
            .req_i  (req_i[c]),
            .en_i   (en_i[c]),
            .win_i  (win_i),
            .clr_i  (clr_w[c]),
            .pend_o (pend_o[c])
        );
    end

    dma_prio_pick #(.N(N)) pick_i (
        .cand_i (pend_o & en_i),
        .pick_o (pick_w),
        .any_o  (any_w)
    );

    dma_bus_seq #(.N(N)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .pick_i      (pick_w),
        .any_i       (any_w),
        .cpu_done_i  (cpu_done_i),
        .xfer_done_i (xfer_done_i),
        .clr_o       (clr_w),
        .grant_o     (grant_o),
        .cpu_own_o   (cpu_own_o)
    );

endmodule

// File: rtl/dma_req_arb_chk.sv
module dma_req_arb_chk #(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] en_i,
    input logic         win_i,
    input logic         cpu_done_i,
    input logic         xfer_done_i,
    input logic [N-1:0] pend_o,
    input logic [N-1:0] grant_o,
    input logic         cpu_own_o
);

    logic cpu_ok_q;

    always_ff @(posedge clk) begin
        if (rst)             cpu_ok_q <= 1'b1;
        else if (|grant_o)   cpu_ok_q <= 1'b0;
        else if (cpu_done_i) cpu_ok_q <= 1'b1;
    end

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R11
    cpu_own_match_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_own_o == !(|grant_o));

    // R7
    xfer_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((|grant_o) && xfer_done_i) |=> cpu_own_o);

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(|grant_o) |-> $past(xfer_done_i));

    // R8
    cpu_between_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|grant_o) |-> cpu_ok_q);

    for (genvar c = 0; c < N; c++) begin : g_chk
        localparam logic [N-1:0] LOWER = N'((1 << c) - 1);

        // R10
        dis_clears_chk: assert property (@(posedge clk) disable iff (rst)
            !en_i[c] |=> !pend_o[c]);

        // R6
        grant_clears_chk: assert property (@(posedge clk) disable iff (rst)
            ($rose(grant_o[c]) && !$past(win_i)) |-> !pend_o[c]);

        // R5
        prio_order_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(grant_o[c]) |-> (($past(pend_o & en_i) & LOWER) == '0));
    end

endmodule

bind dma_req_arb dma_req_arb_chk #(.N(N)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .win_i       (win_i),
    .cpu_done_i  (cpu_done_i),
    .xfer_done_i (xfer_done_i),
    .pend_o      (pend_o),
    .grant_o     (grant_o),
    .cpu_own_o   (cpu_own_o)
);

// File: tb/dma_req_arb_tb_top.sv
module dma_req_arb_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] req = '0, en = '0;
    logic       win = 1'b0, cpu_done = 1'b0, xfer_done = 1'b0;
    logic [1:0] pend, grant;
    logic       cpu_own;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dma_req_arb #(.N(2)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .en_i        (en),
        .win_i       (win),
        .cpu_done_i  (cpu_done),
        .xfer_done_i (xfer_done),
        .pend_o      (pend),
        .grant_o     (grant),
        .cpu_own_o   (cpu_own)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [1:0] exp_p, logic [1:0] exp_g);
        logic exp_c;
        exp_c = (exp_g == 2'b00);
        total++;
        if (pend !== exp_p || grant !== exp_g || cpu_own !== exp_c) begin
            bad++;
            $display("FAIL %s: pend=%b grant=%b cpu_own=%b expected pend=%b grant=%b cpu_own=%b",
                     tag, pend, grant, cpu_own, exp_p, exp_g, exp_c);
        end
    endtask

    task automatic pulse_xfer();
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
    endtask

    task automatic pulse_cpu();
        cpu_done = 1'b1; step(); cpu_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset state", 2'b00, 2'b00);
    endtask

    task automatic t_both_window();
        en = 2'b11; req = 2'b11; step();
        req = 2'b00; win = 1'b1; step(); win = 1'b0;
        chk("R2 both latched together", 2'b11, 2'b00);
        step();
        chk("R5 R6 ch0 wins, its flag cleared", 2'b10, 2'b01);
        step();
        chk("R7 grant held without done", 2'b10, 2'b01);
        pulse_xfer();
        chk("R7 bus back to cpu", 2'b10, 2'b00);
        step(); step();
        chk("R8 ch1 waits for cpu access", 2'b10, 2'b00);
        pulse_cpu();
        chk("R8 no grant on cpu_done edge", 2'b10, 2'b00);
        step();
        chk("R8 ch1 granted after cpu access", 2'b00, 2'b10);
        pulse_xfer(); pulse_cpu(); step();
        chk("R11 idle after both", 2'b00, 2'b00);
    endtask

    task automatic t_disabled();
        en = 2'b01; req = 2'b10; win = 1'b1; step(); win = 1'b0; req = 2'b00;
        chk("R3 disabled request ignored", 2'b00, 2'b00);
        step(); step();
        chk("R3 no grant for disabled", 2'b00, 2'b00);
    endtask

    task automatic t_merge();
        en = 2'b01;
        req = 2'b01; step(); req = 2'b00; step();
        req = 2'b01; step(); req = 2'b00; win = 1'b1; step(); win = 1'b0;
        chk("R4 merged pending", 2'b01, 2'b00);
        step();
        chk("R4 single grant", 2'b00, 2'b01);
        pulse_xfer();
        req = 2'b01; win = 1'b1; step(); win = 1'b0; req = 2'b00;
        req = 2'b01; win = 1'b1; step(); win = 1'b0; req = 2'b00;
        chk("R4 two windows merged while cpu owns", 2'b01, 2'b00);
        pulse_cpu(); step();
        chk("R4 served once", 2'b00, 2'b01);
        pulse_xfer(); pulse_cpu(); step(); step(); step();
        chk("R4 no extra transfer", 2'b00, 2'b00);
    endtask

    task automatic t_rereq();
        en = 2'b01; req = 2'b01; win = 1'b1; step(); win = 1'b0; req = 2'b00;
        step();
        chk("R9 granted", 2'b00, 2'b01);
        req = 2'b01; win = 1'b1; step(); win = 1'b0; req = 2'b00;
        chk("R9 re-set during own transfer", 2'b01, 2'b01);
        pulse_xfer();
        chk("R9 bus released", 2'b01, 2'b00);
        step();
        chk("R8 R9 held until cpu access", 2'b01, 2'b00);
        pulse_cpu(); step();
        chk("R9 served again", 2'b00, 2'b01);
        pulse_xfer(); pulse_cpu(); step();
    endtask

    task automatic t_disable();
        en = 2'b11; req = 2'b11; win = 1'b1; step(); win = 1'b0; req = 2'b00;
        step();
        chk("R5 ch0 first", 2'b10, 2'b01);
        en = 2'b01; step();
        chk("R10 disable clears ch1 flag", 2'b00, 2'b01);
        en = 2'b00; step(); step();
        chk("R10 granted transfer continues", 2'b00, 2'b01);
        pulse_xfer();
        chk("R10 transfer ends normally", 2'b00, 2'b00);
        pulse_cpu(); step(); step();
        chk("R10 nothing left to serve", 2'b00, 2'b00);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_both_window();
        t_disabled();
        t_merge();
        t_rereq();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule